// File: doc/BRIEF.md
# Breakpoint Address Match Unit

This unit checks every memory access or instruction fetch against four independently configured breakpoints. Each breakpoint carries a linear address, a two-bit kind field, a two-bit size field and two enable bits, one local and one global. For each breakpoint the unit reports whether the current access hits it, whatever its enables. It raises a trap request only when at least one breakpoint that hits is enabled at either level.

Data breakpoints cover a small aligned window of bytes. The window size comes from the size field, and the low bits of the configured address are dropped to align the window. A data access hits when any byte it touches lies inside that window. Execution breakpoints hit only on a fetch whose address equals the configured address and that is flagged as the first byte of an instruction. Undefined encodings never hit. The byte range of an access is computed one bit wider than the address, so an access that runs past the top of the address space cannot alias onto low addresses.

The matching logic is combinational. When the parameter `OUT_REG` is 1 (the default), both outputs are registered, which adds one cycle of latency.

Top module: `bkpt_match`

## Requirements
- R1: A breakpoint of kind 00 (execute) with size 00 hits only when the access kind is 00 (fetch), `insn_start` is 1, and `acc_addr` equals the breakpoint address exactly.
- R2: An execute breakpoint does not hit when its size field is not 00, when `insn_start` is 0, or when the fetch address differs from the breakpoint address, even by one byte.
- R3: A breakpoint of kind 01 hits only on accesses of kind 10 (write). Accesses of kind 01 (read) never hit it.
- R4: A breakpoint of kind 11 hits on both reads (kind 01) and writes (kind 10). It never hits on a fetch (kind 00).
- R5: A breakpoint with kind field 10, or with size field 10, never hits.
- R6: The window of a breakpoint is aligned by its size code. Code 00 covers one byte. Code 01 covers two bytes, with address bit 0 ignored. Code 11 covers four bytes, with address bits 1:0 ignored.
- R7: A data breakpoint hits when any byte of the access overlaps its window. Access size is coded on `acc_size`: 00 is one byte, 01 is two bytes, 11 is four bytes. The bytes run from `acc_addr` upward.
- R8: Byte ranges are computed in 33 bits, so an access that extends past address FFFFFFFF does not hit a window at address 0.
- R9: `hit_raw[i]` reports breakpoint i whatever its enables. `trap_req` is 1 exactly when some i has `hit_raw[i]` set and `bp_local_en[i]` or `bp_global_en[i]` set.
- R10: No breakpoint hits when `acc_valid` is 0, or when `acc_size` is 10, or when the access kind is 11.
- R11: With `OUT_REG`=1, both outputs are 0 during reset and reflect the inputs of the previous clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 32 | Linear address of the lowest byte of the access |
| acc_size | input | 2 | Access size code (00=1, 01=2, 11=4 bytes, 10 invalid) |
| acc_kind | input | 2 | Access kind (00 fetch, 01 read, 10 write, 11 none) |
| insn_start | input | 1 | Fetch is the first byte of an instruction |
| bp_addr | input | 128 | Breakpoint addresses, breakpoint i in bits 32*i+31:32*i |
| bp_kind | input | 8 | Breakpoint kind fields, two bits each |
| bp_size | input | 8 | Breakpoint size fields, two bits each |
| bp_local_en | input | 4 | Local enables |
| bp_global_en | input | 4 | Global enables |
| hit_raw | output | 4 | Per-breakpoint hit, not gated by the enables |
| trap_req | output | 1 | Some enabled breakpoint hit |

## Verification
The assertions assume that the breakpoint configuration and the access fields are stable, known values whenever reset is released. They also assume that a fetch reaches the unit only with its `insn_start` flag resolved. The bench respects this by driving every input on the falling edge and holding it through the next rising edge. It also programs the breakpoint configuration before each access rather than during it. The vector table replays the aligned overlap cases that are hit and missed. Directed cases then cover the undefined codes, address wrap, the enable levels and the idle access.

// File: rtl/bkpt_match.sv
module bkpt_match #(
  parameter int AW      = 32,
  parameter int N_BP    = 4,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [AW-1:0]     acc_addr,
  input  logic [1:0]        acc_size,
  input  logic [1:0]        acc_kind,
  input  logic              insn_start,
  input  logic [N_BP*AW-1:0] bp_addr,
  input  logic [N_BP*2-1:0] bp_kind,
  input  logic [N_BP*2-1:0] bp_size,
  input  logic [N_BP-1:0]   bp_local_en,
  input  logic [N_BP-1:0]   bp_global_en,
  output logic [N_BP-1:0]   hit_raw,
  output logic              trap_req
);
  localparam int XW = AW + 1;

  localparam logic [1:0] K_FETCH = 2'b00;
  localparam logic [1:0] K_READ  = 2'b01;
  localparam logic [1:0] K_WRITE = 2'b10;

  function automatic logic [XW-1:0] span(input logic [1:0] code);
    case (code)
      2'b01:   span = XW'(1);
      2'b11:   span = XW'(3);
      default: span = '0;
    endcase
  endfunction

  logic            size_ok;
  logic            is_data;
  logic [XW-1:0]   a_lo, a_hi;
  logic [N_BP-1:0] hit_c;
  logic            trap_c;

  assign size_ok = (acc_size != 2'b10);
  assign is_data = (acc_kind == K_READ) || (acc_kind == K_WRITE);
  assign a_lo    = {1'b0, acc_addr};
  assign a_hi    = a_lo + span(acc_size);

  for (genvar i = 0; i < N_BP; i++) begin : g_bp
    logic [AW-1:0] ba;
    logic [1:0]    bk, bs;
    logic [XW-1:0] w_lo, w_hi;
    logic          overlap, exec_hit, data_hit;

    assign ba   = bp_addr[i*AW +: AW];
    assign bk   = bp_kind[i*2 +: 2];
    assign bs   = bp_size[i*2 +: 2];
    assign w_lo = {1'b0, ba} & ~span(bs);
    assign w_hi = w_lo + span(bs);

    assign overlap  = (a_lo <= w_hi) && (w_lo <= a_hi);
    assign exec_hit = (bk == 2'b00) && (bs == 2'b00) && (acc_kind == K_FETCH)
                      && insn_start && (acc_addr == ba);
    assign data_hit = is_data && (bs != 2'b10) && overlap &&
                      ((bk == 2'b11) || (bk == 2'b01 && acc_kind == K_WRITE));
    assign hit_c[i] = acc_valid && size_ok && (exec_hit || data_hit);

    p_reserved_never_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bk == 2'b10 || bs == 2'b10) |-> !hit_c[i]);
    p_exec_exact_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_c[i] && bk == 2'b00) |-> (acc_kind == K_FETCH && insn_start && acc_addr == ba));
    p_write_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_c[i] && bk == 2'b01) |-> (acc_kind == K_WRITE));
    p_data_no_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_c[i] && bk != 2'b00) |-> (acc_kind != K_FETCH));
  end

  assign trap_c = |(hit_c & (bp_local_en | bp_global_en));

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hit_raw  <= '0;
        trap_req <= 1'b0;
      end else begin
        hit_raw  <= hit_c;
        trap_req <= trap_c;
      end
    end

    p_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!acc_valid) && $past(rst_n) |-> (hit_raw == '0 && !trap_req));
  end else begin : g_comb
    assign hit_raw  = hit_c;
    assign trap_req = trap_c;
  end

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_valid || acc_kind == 2'b11) |-> (hit_c == '0));
  p_trap_needs_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (hit_raw != '0));
endmodule

// File: tb/tb_bkpt_match.sv
module tb_bkpt_match;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [1:0]  acc_size = '0;
  logic [1:0]  acc_kind = 2'b11;
  logic        insn_start = 1'b0;
  logic [127:0] bp_addr = '0;
  logic [7:0]  bp_kind = '0;
  logic [7:0]  bp_size = '0;
  logic [3:0]  bp_local_en = '0;
  logic [3:0]  bp_global_en = '0;
  logic [3:0]  hit_raw;
  logic        trap_req;

  int checks = 0;
  int failures = 0;

  bkpt_match dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_size(acc_size), .acc_kind(acc_kind), .insn_start(insn_start),
    .bp_addr(bp_addr), .bp_kind(bp_kind), .bp_size(bp_size),
    .bp_local_en(bp_local_en), .bp_global_en(bp_global_en),
    .hit_raw(hit_raw), .trap_req(trap_req)
  );

  always #10 clk = ~clk;

  // {addr, size, kind, expected hits}
  localparam int NV = 14;
  localparam logic [39:0] VEC [NV] = '{
    {32'h000A0001, 2'b00, 2'b01, 4'b0001},
    {32'h000A0002, 2'b00, 2'b01, 4'b0010},
    {32'h000A0001, 2'b01, 2'b01, 4'b0011},
    {32'h000A0002, 2'b01, 2'b10, 4'b0010},
    {32'h000B0002, 2'b01, 2'b01, 4'b0100},
    {32'h000B0001, 2'b11, 2'b10, 4'b0100},
    {32'h000C0000, 2'b11, 2'b01, 4'b1000},
    {32'h000C0001, 2'b01, 2'b10, 4'b1000},
    {32'h000C0003, 2'b00, 2'b01, 4'b1000},
    {32'h000A0000, 2'b00, 2'b01, 4'b0000},
    {32'h000A0003, 2'b11, 2'b01, 4'b0000},
    {32'h000B0000, 2'b01, 2'b10, 4'b0000},
    {32'h000C0004, 2'b11, 2'b01, 4'b0000},
    {32'h000A0001, 2'b00, 2'b00, 4'b0000}
  };

  task automatic chk(input string req, input logic [3:0] eh, input logic et);
    checks++;
    if (hit_raw !== eh || trap_req !== et) begin
      failures++;
      $display("FAIL %s hit=%b trap=%b expected hit=%b trap=%b", req, hit_raw, trap_req, eh, et);
    end
  endtask

  task automatic acc(input logic [31:0] a, input logic [1:0] s, input logic [1:0] k, input logic st);
    acc_valid = 1'b1; acc_addr = a; acc_size = s; acc_kind = k; insn_start = st;
    @(negedge clk);
  endtask

  task automatic setbp(input int i, input logic [31:0] a, input logic [1:0] k, input logic [1:0] s);
    bp_addr[i*32 +: 32] = a; bp_kind[i*2 +: 2] = k; bp_size[i*2 +: 2] = s;
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    setbp(0, 32'h000A0001, 2'b11, 2'b00);
    setbp(1, 32'h000A0002, 2'b11, 2'b00);
    setbp(2, 32'h000B0002, 2'b11, 2'b01);
    setbp(3, 32'h000C0000, 2'b11, 2'b11);
    acc_valid = 1'b1; acc_addr = 32'h000A0001; acc_kind = 2'b01;
    bp_local_en = 4'b0001;
    repeat (3) @(negedge clk);
    chk("R11 reset", 4'b0000, 1'b0);
    rst_n = 1'b1;
    acc_valid = 1'b0;
    @(negedge clk);

    // R6 R7 table: local enable on bp0 only
    for (int v = 0; v < NV; v++) begin
      acc(VEC[v][39:8], VEC[v][7:6], VEC[v][5:4], 1'b0);
      chk("R7 table", VEC[v][3:0], VEC[v][0]);
    end

    // R11 latency: output holds old value until the next edge
    acc(32'h000C0000, 2'b11, 2'b01, 1'b0);
    acc_addr = 32'h000A0001; acc_size = 2'b00;
    #1 chk("R11 hold", 4'b1000, 1'b0);
    @(negedge clk);
    chk("R11 update", 4'b0001, 1'b1);

    bp_local_en = '0; bp_global_en = '0;
    setbp(0, 32'h00001000, 2'b00, 2'b00);
    acc(32'h00001000, 2'b00, 2'b00, 1'b1);
    chk("R1 exec hit", 4'b0001, 1'b0);
    acc(32'h00001000, 2'b00, 2'b00, 1'b0);
    chk("R2 no insn_start", 4'b0000, 1'b0);
    acc(32'h00001001, 2'b00, 2'b00, 1'b1);
    chk("R2 addr off by one", 4'b0000, 1'b0);
    setbp(0, 32'h00001000, 2'b00, 2'b01);
    acc(32'h00001000, 2'b00, 2'b00, 1'b1);
    chk("R2 exec size 01", 4'b0000, 1'b0);
    setbp(0, 32'h00001000, 2'b00, 2'b00);
    acc(32'h00001000, 2'b00, 2'b01, 1'b1);
    chk("R1 exec not on read", 4'b0000, 1'b0);

    setbp(1, 32'h00002000, 2'b01, 2'b00);
    acc(32'h00002000, 2'b00, 2'b10, 1'b0);
    chk("R3 write hits", 4'b0010, 1'b0);
    acc(32'h00002000, 2'b00, 2'b01, 1'b0);
    chk("R3 read ignored", 4'b0000, 1'b0);

    setbp(2, 32'h00003000, 2'b11, 2'b00);
    acc(32'h00003000, 2'b00, 2'b00, 1'b1);
    chk("R4 fetch ignored", 4'b0000, 1'b0);
    acc(32'h00003000, 2'b00, 2'b10, 1'b0);
    chk("R4 write hits", 4'b0100, 1'b0);
    setbp(2, 32'h00003000, 2'b10, 2'b00);
    acc(32'h00003000, 2'b00, 2'b10, 1'b0);
    chk("R5 kind 10", 4'b0000, 1'b0);
    setbp(2, 32'h00003000, 2'b11, 2'b10);
    acc(32'h00003000, 2'b00, 2'b01, 1'b0);
    chk("R5 size 10", 4'b0000, 1'b0);

    setbp(3, 32'h00004003, 2'b11, 2'b11);
    acc(32'h00004000, 2'b00, 2'b01, 1'b0);
    chk("R6 four-byte align", 4'b1000, 1'b0);
    setbp(3, 32'h00004003, 2'b11, 2'b01);
    acc(32'h00004002, 2'b00, 2'b01, 1'b0);
    chk("R6 two-byte align", 4'b1000, 1'b0);
    acc(32'h00004001, 2'b00, 2'b01, 1'b0);
    chk("R6 outside window", 4'b0000, 1'b0);

    setbp(3, 32'h00000000, 2'b11, 2'b11);
    acc(32'hFFFFFFFF, 2'b11, 2'b01, 1'b0);
    chk("R8 no wrap alias", 4'b0000, 1'b0);
    setbp(3, 32'hFFFFFFFC, 2'b11, 2'b11);
    acc(32'hFFFFFFFE, 2'b11, 2'b01, 1'b0);
    chk("R8 top window", 4'b1000, 1'b0);

    acc(32'hFFFFFFFE, 2'b11, 2'b01, 1'b0);
    chk("R9 disabled raw", 4'b1000, 1'b0);
    bp_global_en = 4'b1000;
    acc(32'hFFFFFFFE, 2'b11, 2'b01, 1'b0);
    chk("R9 global enable", 4'b1000, 1'b1);
    bp_global_en = 4'b0000; bp_local_en = 4'b0111;
    acc(32'hFFFFFFFE, 2'b11, 2'b01, 1'b0);
    chk("R9 other enables", 4'b1000, 1'b0);
    bp_local_en = 4'b1000;
    acc(32'hFFFFFFFE, 2'b11, 2'b01, 1'b0);
    chk("R9 local enable", 4'b1000, 1'b1);

    acc(32'hFFFFFFFE, 2'b10, 2'b01, 1'b0);
    chk("R10 size 10", 4'b0000, 1'b0);
    acc(32'hFFFFFFFE, 2'b11, 2'b11, 1'b0);
    chk("R10 kind none", 4'b0000, 1'b0);
    acc_valid = 1'b0; acc_kind = 2'b01;
    @(negedge clk);
    chk("R10 not valid", 4'b0000, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule